// File: doc/BRIEF.md
# Successive-Approximation Converter Clock and Channel Scanner

This block is the digital half of a 10-bit successive-approximation converter that serves four multiplexed analogue inputs. A prescaler divides the system clock down to a converter tick. The divide ratio is selected by a 3-bit code, and one code value stops the tick entirely. On each tick the scanner advances one step of a 12-step conversion. The first two steps let the input multiplexer and the comparator settle. The other ten run a binary search against an external comparator, which reports whether the selected input is at or above the trial code now on the DAC output.

Scanning repeats over all enabled channels for as long as it is allowed. Each channel's last finished result is held in its own register. Scanning is allowed only when all of these hold: the run control is high, the prescaler is not stopped, channel 1 is enabled, and the halt latch is clear. Channel 1 is index 0. A read of channel 1's result sets the halt latch, so the results freeze for the reader. A fresh write of the run control with value 1 clears the latch again. Whenever scanning is not allowed, the sequence drops back to its idle state, and the next start begins at channel 1.

Top module: `sar_scan_seq`

## Requirements
- R1: Divider code k in 1..7 divides the clock by 2^(k-1). From the first clock edge at which scanning is allowed, one conversion finishes after exactly 12*2^(k-1) clock edges, when a single channel is enabled.
- R2: Divider code 0 stops the converter tick. No result changes, and trialCode stays 0.
- R3: A conversion has two settling steps, during which trialCode is 0. These are followed by ten decision steps. Decision n (n = 0..9) drives the bits kept so far, with bit 9-n also set. That bit is kept when cmpHigh is 1, and cmpHigh = 1 means the input is at or above trialCode. With an ideal comparator the result equals the input code.
- R4: A result register changes only on the last decision step. Before that, it still shows the previous completed value.
- R5: Enabled channels are converted in ascending index order, with wrap-around, and disabled channels are skipped. muxSel changes only while trialCode is 0, i.e. at the start of the settling steps. In idle, muxSel is 3.
- R6: With chanEn[0] = 0 no conversion runs and trialCode stays 0, whatever the other enables are.
- R7: runBit = 0 stops scanning and discards a conversion in progress. The next start begins afresh at channel index 0.
- R8: A one-cycle rd1Stb pulse halts scanning. Scanning stays halted until a runWr pulse is given while runBit = 1.
- R9: A disabled channel's result register keeps its value while other channels convert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divCode | input | 3 | Prescaler code: 0 stops the tick, k divides by 2^(k-1) |
| chanEn | input | 4 | Per-channel enable, bit i enables channel index i |
| runBit | input | 1 | Continuous-scan control level |
| runWr | input | 1 | Strobe: the run control was written, and it clears the halt latch if runBit is 1 |
| rd1Stb | input | 1 | Strobe: channel index 0 result was read |
| cmpHigh | input | 1 | Comparator: 1 when the selected input is at or above trialCode |
| trialCode | output | 10 | Trial code to the external DAC, 0 outside decision steps |
| muxSel | output | 2 | Input multiplexer select |
| resAll | output | 40 | Channel results, channel i in bits [10*i+9:10*i] |

## Verification
The hardest cases to reach are the ones where scanning stops partway through a conversion: halting, aborting or restarting must leave every result register exactly as it was. The stimulus reaches them by dropping runBit after a few ticks, by pulsing rd1Stb while all four channels are scanning, and by enabling only the upper channels. In each case the input voltages are changed first, so any stray write would show at the ports. The binary search itself is swept over all 1024 input codes. Every divide ratio is timed by sampling the result one edge before and one edge after the expected completion.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int RES_W   = 10;
  localparam int NUM_CH  = 4;
  localparam int SETTLE  = 2;
  localparam int DIV_W   = 3;
  localparam int IDX_W   = $clog2(RES_W);

  // control -> datapath strobes
  typedef struct packed {
    logic             clear;   // start of conversion
    logic             trial;   // level: decision step in progress
    logic             decide;  // tick during a decision step
    logic             commit;  // tick on the last decision step
    logic [IDX_W-1:0] bitIdx;  // bit under test
  } seqStb_t;
endpackage

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NCH    = NUM_CH,
  parameter int RES    = RES_W,
  parameter int SETTLEN = SETTLE,
  parameter int DIVW   = DIV_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DIVW-1:0]        divCode,
  input  logic [NCH-1:0]         chanEn,
  input  logic                   runBit,
  input  logic                   runWr,
  input  logic                   rd1Stb,
  output logic [$clog2(NCH)-1:0] chSel,
  output seqStb_t                stb
);
  localparam int STEPS = RES + SETTLEN;
  localparam int STW   = $clog2(STEPS);
  localparam int CHW   = $clog2(NCH);
  localparam int CNTW  = (1 << DIVW) - 2;

  logic [CNTW-1:0] preCnt, divLim;
  logic [STW-1:0]  step;
  logic [CHW-1:0]  curCh, nextCh;
  logic            halted, active, tick, found;

  // R6 R7 R8: scanning allowed only with channel 0 enabled, run high, not halted
  assign active = runBit && chanEn[0] && !halted && (divCode != '0);

  // R1: divide limit = 2^(code-1) - 1
  always_comb begin
    int sh;
    sh     = CNTW + 1 - int'(divCode);
    divLim = {CNTW{1'b1}} >> sh;
  end

  assign tick = active && (preCnt == divLim);

  // R5: next enabled channel above the current one, wrapping
  always_comb begin
    logic [CHW-1:0] idx;
    nextCh = curCh;
    found  = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      idx = CHW'((int'(curCh) + i) % NCH);
      if (!found && chanEn[idx]) begin
        nextCh = idx;
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      step   <= '0;
      curCh  <= CHW'(NCH - 1);
      halted <= 1'b0;
    end else begin
      // R8: halt on read, release on a run write of 1
      if (runWr && runBit)  halted <= 1'b0;
      else if (rd1Stb)      halted <= 1'b1;

      if (!active) begin
        preCnt <= '0;
        step   <= '0;
        curCh  <= CHW'(NCH - 1);
      end else begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick) begin
          if (step == '0) curCh <= nextCh;
          step <= (step == STW'(STEPS - 1)) ? '0 : step + 1'b1;
        end
      end
    end
  end

  assign chSel      = curCh;
  assign stb.clear  = tick && (step == '0);
  assign stb.trial  = (step >= STW'(SETTLEN));
  assign stb.decide = tick && stb.trial;
  assign stb.commit = tick && (step == STW'(STEPS - 1));
  assign stb.bitIdx = IDX_W'(RES - 1 + SETTLEN - int'(step));
endmodule

// File: rtl/sar_dpath.sv
`timescale 1ns/1ps
module sar_dpath
  import sar_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int RES = RES_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStb_t                stb,
  input  logic [$clog2(NCH)-1:0] chSel,
  input  logic                   cmpHigh,
  output logic [RES-1:0]         trialCode,
  output logic [NCH*RES-1:0]     resAll
);
  logic [RES-1:0] sar;

  // R3: trial = kept bits plus the bit under test
  assign trialCode = stb.trial ? (sar | (RES'(1) << stb.bitIdx)) : '0;

  always_ff @(posedge clk) begin
    if (!rstN)                       sar <= '0;
    else if (stb.clear)              sar <= '0;
    else if (stb.decide && cmpHigh)  sar <= trialCode;
  end

  // R4 R9: one result register per channel, written only on commit
  for (genvar c = 0; c < NCH; c++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN)
        resAll[c*RES +: RES] <= '0;
      else if (stb.commit && (int'(chSel) == c))
        resAll[c*RES +: RES] <= cmpHigh ? trialCode : sar;
    end
  end
endmodule

// File: rtl/sar_scan_seq.sv
`timescale 1ns/1ps
module sar_scan_seq
  import sar_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int RES  = RES_W,
  parameter int DIVW = DIV_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DIVW-1:0]        divCode,
  input  logic [NCH-1:0]         chanEn,
  input  logic                   runBit,
  input  logic                   runWr,
  input  logic                   rd1Stb,
  input  logic                   cmpHigh,
  output logic [RES-1:0]         trialCode,
  output logic [$clog2(NCH)-1:0] muxSel,
  output logic [NCH*RES-1:0]     resAll
);
  seqStb_t stb;

  sar_ctrl #(.NCH(NCH), .RES(RES), .SETTLEN(SETTLE), .DIVW(DIVW)) u_ctrl (
    .clk(clk), .rstN(rstN), .divCode(divCode), .chanEn(chanEn),
    .runBit(runBit), .runWr(runWr), .rd1Stb(rd1Stb),
    .chSel(muxSel), .stb(stb)
  );

  sar_dpath #(.NCH(NCH), .RES(RES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .chSel(muxSel),
    .cmpHigh(cmpHigh), .trialCode(trialCode), .resAll(resAll)
  );
endmodule

// File: rtl/sar_scan_chk.sv
`timescale 1ns/1ps
module sar_scan_chk #(
  parameter int NCH  = 4,
  parameter int RES  = 10,
  parameter int DIVW = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [DIVW-1:0]        divCode,
  input logic [NCH-1:0]         chanEn,
  input logic [RES-1:0]         trialCode,
  input logic [$clog2(NCH)-1:0] muxSel,
  input logic [NCH*RES-1:0]     resAll
);
  // R5
  mux_in_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(muxSel) |-> (trialCode == '0));

  // R2
  stopped_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(divCode) == '0) |-> ($stable(resAll) && trialCode == '0));

  // R4
  commit_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resAll) |-> $past(trialCode[0]));

  // R6
  need_chan0_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!chanEn[0]) |-> (trialCode == '0 && $stable(resAll)));
endmodule

bind sar_scan_seq sar_scan_chk #(.NCH(NCH), .RES(RES), .DIVW(DIVW)) u_chk (
  .clk(clk), .rstN(rstN), .divCode(divCode), .chanEn(chanEn),
  .trialCode(trialCode), .muxSel(muxSel), .resAll(resAll)
);

// File: tb/sim_sar_scan_seq.sv
`timescale 1ns/1ps
module sim_sar_scan_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] divCode = 3'd1;
  logic [3:0] chanEn = 4'b0000;
  logic       runBit = 1'b0, runWr = 1'b0, rd1Stb = 1'b0;
  logic       cmpHigh;
  logic [9:0] trialCode;
  logic [1:0] muxSel;
  logic [39:0] resAll;
  logic [9:0] vin [4];
  logic [9:0] expRes [4];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  // ideal analogue model: input at or above trial level
  assign cmpHigh = (vin[muxSel] >= trialCode);

  sar_scan_seq u0 (
    .clk(clk), .rstN(rstN), .divCode(divCode), .chanEn(chanEn),
    .runBit(runBit), .runWr(runWr), .rd1Stb(rd1Stb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .muxSel(muxSel), .resAll(resAll)
  );

  function automatic logic [9:0] resOf(int i);
    return resAll[i*10 +: 10];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkAll(string req);
    for (int i = 0; i < 4; i++) chk(req, resOf(i), expRes[i]);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin vin[i] = '0; expRes[i] = '0; end
    cyc(3);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chkAll("reset");
    chk("reset R5 muxSel", muxSel, 3);
    chk("reset trialCode", trialCode, 0);

    // R1 and R4: timing for each divide code
    chanEn = 4'b0001;
    for (int k = 1; k <= 7; k++) begin
      int div;
      div = 1 << (k - 1);
      runBit = 1'b0; divCode = 3'(k);
      cyc(1);
      vin[0] = 10'(k * 97 + 3);
      runBit = 1'b1;
      cyc(12 * div - 1);
      chk("R4 previous value before last step", resOf(0), expRes[0]);
      cyc(1);
      chk("R1 completion time", resOf(0), vin[0]);
      expRes[0] = vin[0];
    end

    // R2: stopped tick
    runBit = 1'b0; cyc(1);
    divCode = 3'd0; chanEn = 4'b1111;
    for (int i = 0; i < 4; i++) vin[i] = 10'(400 + i);
    runBit = 1'b1;
    cyc(300);
    chkAll("R2 stopped tick");
    chk("R2 trialCode", trialCode, 0);

    // R3: every input code
    divCode = 3'd1; chanEn = 4'b0001;
    for (int v = 0; v < 1024; v++) begin
      runBit = 1'b0; cyc(1);
      vin[0] = 10'(v);
      runBit = 1'b1;
      cyc(12);
      chk("R3 binary search", resOf(0), v);
    end
    expRes[0] = 10'd1023;

    // R5 and R9: enable masks with channel 0 set
    for (int m = 0; m < 8; m++) begin
      logic [3:0] mask;
      mask = {3'(m), 1'b1};
      runBit = 1'b0; cyc(1);
      chanEn = mask;
      for (int i = 0; i < 4; i++) vin[i] = 10'((m * 131 + i * 251 + 17) % 1024);
      runBit = 1'b1;
      cyc(60);
      for (int i = 0; i < 4; i++) begin
        if (mask[i]) expRes[i] = vin[i];
        chk(mask[i] ? "R5 enabled channel" : "R9 disabled channel held",
            resOf(i), expRes[i]);
      end
    end

    // R5: visiting order with channel 2 disabled
    begin
      int seen [5];
      int nSeen;
      logic [1:0] last;
      runBit = 1'b0; cyc(1);
      chanEn = 4'b1011;
      last = muxSel; nSeen = 0;
      runBit = 1'b1;
      for (int c = 0; c < 80; c++) begin
        cyc(1);
        if (muxSel != last && nSeen < 5) begin
          seen[nSeen] = muxSel; nSeen++;
        end
        last = muxSel;
      end
      chk("R5 order count", nSeen, 5);
      chk("R5 order 0", seen[0], 0);
      chk("R5 order 1", seen[1], 1);
      chk("R5 order 2", seen[2], 3);
      chk("R5 order 3", seen[3], 0);
      chk("R5 order 4", seen[4], 1);
      for (int i = 0; i < 4; i++) if (chanEn[i]) expRes[i] = vin[i];
    end

    // R6: channel 0 disabled
    runBit = 1'b0; cyc(1);
    chanEn = 4'b1110;
    for (int i = 0; i < 4; i++) vin[i] = 10'(700 + 3 * i);
    runBit = 1'b1;
    cyc(100);
    chkAll("R6 no channel 0");
    chk("R6 trialCode", trialCode, 0);

    // R7: abort mid-conversion, restart from scratch
    runBit = 1'b0; cyc(1);
    chanEn = 4'b0001; vin[0] = 10'd333;
    runBit = 1'b1;
    cyc(6);
    runBit = 1'b0;
    cyc(30);
    chk("R7 aborted conversion discarded", resOf(0), expRes[0]);
    chk("R7 idle trialCode", trialCode, 0);
    runBit = 1'b1;
    cyc(11);
    chk("R7 restart not early", resOf(0), expRes[0]);
    cyc(1);
    chk("R7 restart full conversion", resOf(0), 333);
    expRes[0] = 10'd333;

    // R8: read halts until run written with 1
    runBit = 1'b0; cyc(1);
    chanEn = 4'b1111;
    for (int i = 0; i < 4; i++) vin[i] = 10'(50 + 200 * i);
    runBit = 1'b1;
    cyc(60);
    for (int i = 0; i < 4; i++) expRes[i] = vin[i];
    chkAll("R8 before halt");
    rd1Stb = 1'b1; cyc(1); rd1Stb = 1'b0;
    for (int i = 0; i < 4; i++) vin[i] = 10'(900 - 100 * i);
    cyc(120);
    chkAll("R8 halted after read");
    runWr = 1'b1; cyc(1); runWr = 1'b0;
    cyc(60);
    for (int i = 0; i < 4; i++) expRes[i] = vin[i];
    chkAll("R8 resumed after run write");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule